// File: doc/BRIEF.md
# Serial LED Driver Chain Controller

This block sits on the host side of a daisy chain of latched constant-current LED driver devices. A parallel request interface hands it one frame of `NUM_DEV * BITS_PER_DEV` bits. The controller shifts that frame out on a serial data line and a shift clock, waits for a clock-to-strobe gap, and then pulses the latch strobe so that every device in the chain moves its shift register into its output latches together.

All link timing is set from absolute nanosecond minimums, which are turned into system-clock cycle counts with ceiling rounding. These minimums cover data setup and hold, clock high and low width, clock period, the gap before the strobe, the strobe width and the blanking width. The controller also drives the active-low output-enable line. A blanking request raises that line for at least the minimum blank width. Release is held back while a strobe is in flight.

A `start` pulse is accepted whenever `busy` is low. `busy` stays high through shifting, gap and strobe. `done` pulses for one cycle when the strobe has ended.

Top module: `ledchain_ctrl`

## Requirements
- R1: While `rst` is high, `ser_clk`, `ser_latch`, `ser_data`, `busy` and `done` are 0 and `out_en_n` is 1.
- R2: A `start` seen while `busy` is low loads `frame`, and `busy` is 1 on the following cycle. The frame is sent most-significant bit first with exactly `NUM_DEV*BITS_PER_DEV` rising edges of `ser_clk`. A receiver that shifts `ser_data` into bit 0 on each rising edge therefore holds `frame` unchanged when the strobe falls.
- R3: `ser_data` is stable for at least SETUP_NS before every rising `ser_clk` edge. It changes no sooner than HOLD_NS after that edge, and only while `ser_clk` is low.
- R4: Each high phase and each low phase of `ser_clk` lasts at least 50 ns. Rising edges are at least CLK_PER_NS (100 ns, which keeps the rate at or below 10 MHz) apart.
- R5: `ser_latch` rises no sooner than GAP_NS after the last falling `ser_clk` edge and stays high for at least STROBE_NS. `ser_clk` is low throughout the strobe.
- R6: `done` is high for exactly one cycle after `ser_latch` falls, with `busy` low in that cycle. A new `start` is accepted from that cycle onward.
- R7: A `start` asserted while `busy` is high is ignored. The frame in flight completes unchanged, with no extra clock edges.
- R8: A blanking request of any length drives `out_en_n` high from the cycle after it is sampled. For a short request this lasts exactly ceil(BLANK_NS/CLK_NS) cycles (900 at defaults).
- R9: While `blank_req` stays high, `out_en_n` stays high past the minimum width. It falls one cycle after the request drops once the minimum has elapsed.
- R10: If the minimum blank width runs out while `ser_latch` is high, `out_en_n` stays high until the strobe ends. It falls on the second cycle after `ser_latch` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send `frame` |
| frame | input | NUM_DEV*BITS_PER_DEV | Frame to send, MSB first |
| blank_req | input | 1 | Request to blank all driver outputs |
| busy | output | 1 | A frame is being sent |
| done | output | 1 | One-cycle completion pulse |
| ser_data | output | 1 | Serial data to the first device |
| ser_clk | output | 1 | Shift clock, data taken on the rising edge |
| ser_latch | output | 1 | Latch strobe, active high |
| out_en_n | output | 1 | Output enable, high blanks the drivers |

## Verification
The embedded properties assume that `blank_req` and `start` are synchronous to `clk` and free of glitches. They also assume the cycle-count parameters are at least 1, so every phase lasts at least one cycle. The stimulus drives both inputs only on falling `clk` edges and keeps the default timing parameters. Link timing is measured in absolute nanoseconds by a behavioural chain model, not in cycles. To test deferred release, a start request is placed so that the blank minimum expires partway through a strobe. The placement is worked out from a measured start-to-strobe latency.

// File: rtl/ledchain_pkg.sv
`timescale 1ns/1ps
package ledchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT_LO,
    ST_SHIFT_HI,
    ST_GAP,
    ST_STROBE,
    ST_DONE
  } link_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ledchain_timer.sv
`timescale 1ns/1ps
module ledchain_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  a_r8_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ledchain_shifter.sv
`timescale 1ns/1ps
module ledchain_shifter #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [FW-1:0] frame,
  output logic          bit_out,
  output logic          last
);
  localparam int IW = $clog2(FW);

  logic [FW-1:0] shreg;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      idx   <= '0;
    end else if (load) begin
      shreg <= frame;
      idx   <= '0;
    end else if (adv) begin
      shreg <= {shreg[FW-2:0], 1'b0};
      idx   <= idx + 1'b1;
    end
  end

  assign bit_out = shreg[FW-1];
  assign last    = (idx == IW'(FW - 1));

  a_r2_no_advance_past_end: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |-> !last);

endmodule

// File: rtl/ledchain_blank.sv
`timescale 1ns/1ps
module ledchain_blank #(
  parameter int BLANK_CYC = 900
) (
  input  logic clk,
  input  logic rst,
  input  logic blank_req,
  input  logic strobe_on,
  output logic out_en_n
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic          blanking;
  logic          arm;
  logic          min_met;

  assign arm = blank_req && !blanking;

  ledchain_timer #(.CW(BW)) u_min (
    .clk      (clk),
    .rst      (rst),
    .load     (arm),
    .load_val (BW'(BLANK_CYC - 1)),
    .expired  (min_met)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blanking <= 1'b1;
    end else if (arm) begin
      blanking <= 1'b1;
    end else if (blanking && min_met && !blank_req && !strobe_on) begin
      blanking <= 1'b0;
    end
  end

  assign out_en_n = blanking;

  a_r8_min_width_held: assert property (@(posedge clk) disable iff (rst)
    (blanking && !min_met) |=> blanking);
  a_r9_request_holds: assert property (@(posedge clk) disable iff (rst)
    blank_req |=> blanking);
  a_r10_no_release_in_strobe: assert property (@(posedge clk) disable iff (rst)
    (blanking && strobe_on) |=> blanking);

endmodule

// File: rtl/ledchain_ctrl.sv
`timescale 1ns/1ps
module ledchain_ctrl
  import ledchain_pkg::*;
#(
  parameter int NUM_DEV      = 2,
  parameter int BITS_PER_DEV = 16,
  parameter int CLK_NS       = 5,
  parameter int SETUP_NS     = 50,
  parameter int HOLD_NS      = 20,
  parameter int CLK_HI_NS    = 50,
  parameter int CLK_LO_NS    = 50,
  parameter int CLK_PER_NS   = 100,
  parameter int GAP_NS       = 100,
  parameter int STROBE_NS    = 100,
  parameter int BLANK_NS     = 4500
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [NUM_DEV*BITS_PER_DEV-1:0] frame,
  input  logic                            blank_req,
  output logic                            busy,
  output logic                            done,
  output logic                            ser_data,
  output logic                            ser_clk,
  output logic                            ser_latch,
  output logic                            out_en_n
);
  localparam int FW        = NUM_DEV * BITS_PER_DEV;
  localparam int LO_CYC    = max2(ceil_div(SETUP_NS, CLK_NS), ceil_div(CLK_LO_NS, CLK_NS));
  localparam int HI_MIN    = max2(ceil_div(CLK_HI_NS, CLK_NS), ceil_div(HOLD_NS, CLK_NS));
  localparam int HI_CYC    = max2(HI_MIN, ceil_div(CLK_PER_NS, CLK_NS) - LO_CYC);
  localparam int GAP_CYC   = max2(1, ceil_div(GAP_NS, CLK_NS));
  localparam int STB_CYC   = max2(1, ceil_div(STROBE_NS, CLK_NS));
  localparam int BLANK_CYC = max2(1, ceil_div(BLANK_NS, CLK_NS));
  localparam int TMAX      = max2(max2(LO_CYC, HI_CYC), max2(GAP_CYC, STB_CYC));
  localparam int CW        = $clog2(TMAX + 1);

  link_state_t   state, state_n;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_val;
  logic          sh_load, sh_adv, sh_last;

  ledchain_timer #(.CW(CW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  ledchain_shifter #(.FW(FW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (sh_load),
    .adv     (sh_adv),
    .frame   (frame),
    .bit_out (ser_data),
    .last    (sh_last)
  );

  ledchain_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk       (clk),
    .rst       (rst),
    .blank_req (blank_req),
    .strobe_on (ser_latch),
    .out_en_n  (out_en_n)
  );

  always_comb begin
    state_n  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_adv   = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_n  = ST_SHIFT_LO;
          sh_load  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CW'(LO_CYC - 1);
        end else begin
          state_n = ST_IDLE;
        end
      end
      ST_SHIFT_LO: begin
        if (tmr_exp) begin
          state_n  = ST_SHIFT_HI;
          tmr_load = 1'b1;
          tmr_val  = CW'(HI_CYC - 1);
        end
      end
      ST_SHIFT_HI: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (sh_last) begin
            state_n = ST_GAP;
            tmr_val = CW'(GAP_CYC - 1);
          end else begin
            state_n = ST_SHIFT_LO;
            sh_adv  = 1'b1;
            tmr_val = CW'(LO_CYC - 1);
          end
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          state_n  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CW'(STB_CYC - 1);
        end
      end
      ST_STROBE: begin
        if (tmr_exp) state_n = ST_DONE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ser_clk   <= 1'b0;
      ser_latch <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= state_n;
      ser_clk   <= (state_n == ST_SHIFT_HI);
      ser_latch <= (state_n == ST_STROBE);
      busy      <= (state_n != ST_IDLE) && (state_n != ST_DONE);
      done      <= (state_n == ST_DONE);
    end
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r3_data_moves_clk_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> !ser_clk);
  a_r5_clk_low_in_strobe: assert property (@(posedge clk) disable iff (rst)
    ser_latch |-> !ser_clk);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  a_r6_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(ser_latch));

endmodule

// File: tb/ledchain_ctrl_bench.sv
`timescale 1ns/1ps
module ledchain_ctrl_bench;
  localparam int  W      = 32;
  localparam int  BLANK  = 900;
  localparam real PER_NS = 5.0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] frame = '0;
  logic         blank_req = 1'b0;
  logic busy, done, ser_data, ser_clk, ser_latch, out_en_n;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(PER_NS/2) clk = ~clk;

  ledchain_ctrl u_ledchain_ctrl (
    .clk(clk), .rst(rst), .start(start), .frame(frame), .blank_req(blank_req),
    .busy(busy), .done(done), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .out_en_n(out_en_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural driver chain: shift on rising clock, transparent latch while strobe high.
  logic [W-1:0] chain_sr = '0;
  logic [W-1:0] chain_lat = '0;
  int nclk = 0;
  always @(posedge ser_clk) begin
    chain_sr <= {chain_sr[W-2:0], ser_data};
    nclk++;
  end
  always @(ser_latch or chain_sr) if (ser_latch) chain_lat = chain_sr;

  // Absolute-time link monitors.
  real t_d = -1.0e6, t_rise = -1.0e6, t_fall = -1.0e6, t_lrise = -1.0e6;
  int v_setup = 0, v_hold = 0, v_hi = 0, v_lo = 0, v_per = 0, v_gap = 0, v_stb = 0, v_cl = 0;
  always @(ser_data) begin
    if ($realtime - t_rise < 20.0) v_hold++;
    if (ser_clk === 1'b1) v_hold++;
    t_d = $realtime;
  end
  always @(posedge ser_clk) begin
    if ($realtime - t_d < 50.0) v_setup++;
    if ($realtime - t_fall < 50.0) v_lo++;
    if ($realtime - t_rise < 100.0) v_per++;
    if (ser_latch) v_cl++;
    t_rise = $realtime;
  end
  always @(negedge ser_clk) begin
    if ($realtime - t_rise < 50.0) v_hi++;
    t_fall = $realtime;
  end
  always @(posedge ser_latch) begin
    if ($realtime - t_fall < 100.0) v_gap++;
    t_lrise = $realtime;
  end

  // Scoreboard: expected frames in, latched frames compared at strobe end.
  logic [W-1:0] exp_q[$];
  always @(negedge ser_latch) begin
    if ($realtime - t_lrise < 100.0) v_stb++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R7 unexpected strobe", chain_lat, 0);
    end else begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      chk(chain_lat == e, "R2 latched frame", chain_lat, e);
      chk(nclk == W, "R2/R7 clock edges per frame", nclk, W);
    end
    nclk = 0;
  end

  task automatic send_frame(input logic [W-1:0] f, output int lat_delay);
    lat_delay = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1;
    frame = f;
    exp_q.push_back(f);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    lat_delay = 1;
    while (!ser_latch) begin @(negedge clk); lat_delay++; end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R6 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    int lat, d, hi;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ser_clk, ser_latch, ser_data, busy, done} == 5'b0, "R1 reset outputs low",
        {ser_clk, ser_latch, ser_data, busy, done}, 0);
    chk(out_en_n == 1'b1, "R1 reset blanked", out_en_n, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    send_frame(32'hA5C3_0F81, lat);
    send_frame(32'h0000_0001, lat);
    send_frame(32'hFFFF_FFFF, lat);
    send_frame(32'h8000_0000, lat);

    // R7: start while busy is ignored
    @(negedge clk);
    start = 1'b1; frame = 32'h1234_5678; exp_q.push_back(32'h1234_5678);
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1; frame = 32'hDEAD_BEEF;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R7 no second frame started", busy, 0);
    repeat (5) @(negedge clk);

    // R8: one-cycle blank request
    chk(out_en_n == 1'b0, "R8 enabled before blank", out_en_n, 0);
    blank_req = 1'b1;
    @(negedge clk);
    blank_req = 1'b0;
    hi = 0;
    while (out_en_n && hi < 5000) begin hi++; @(negedge clk); end
    chk(hi == BLANK, "R8 blank width cycles", hi, BLANK);

    // R9: long request
    blank_req = 1'b1;
    repeat (1200) @(negedge clk);
    chk(out_en_n == 1'b1, "R9 held past minimum", out_en_n, 1);
    blank_req = 1'b0;
    @(negedge clk);
    chk(out_en_n == 1'b0, "R9 release one cycle after drop", out_en_n, 0);

    // R10: minimum runs out during strobe
    send_frame(32'h3C3C_5AA5, lat);
    d = BLANK - lat - 8;
    @(negedge clk);
    blank_req = 1'b1;
    @(negedge clk);
    blank_req = 1'b0;
    repeat (d - 1) @(negedge clk);
    start = 1'b1; frame = 32'h0F0F_F0F0; exp_q.push_back(32'h0F0F_F0F0);
    @(negedge clk);
    start = 1'b0;
    while (!ser_latch) @(negedge clk);
    hi = 0;
    while (ser_latch) begin if (!out_en_n) hi++; @(negedge clk); end
    chk(hi == 0, "R10 stays blanked during strobe", hi, 0);
    chk(out_en_n == 1'b1, "R10 still blanked at strobe end", out_en_n, 1);
    @(negedge clk);
    chk(out_en_n == 1'b0, "R10 release after strobe", out_en_n, 0);
    repeat (5) @(negedge clk);

    chk(v_setup == 0 && v_hold == 0, "R3 setup/hold violations", v_setup + v_hold, 0);
    chk(v_hi == 0 && v_lo == 0 && v_per == 0, "R4 clock width violations", v_hi + v_lo + v_per, 0);
    chk(v_gap == 0 && v_stb == 0 && v_cl == 0, "R5 strobe timing violations", v_gap + v_stb + v_cl, 0);
    chk(exp_q.size() == 0, "R2 all frames latched", exp_q.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule